// File: doc/BRIEF.md
# Page-Aligned Flash Program Splitter

This block accepts a single write request for a serial NOR flash. The request gives a 24-bit start address, a byte count and a byte stream that supplies the data. The block splits the write into page-program frames, and no frame crosses a page boundary. Before each program frame it reads the device status until the busy bit is clear, and then it issues a write-enable frame. When the request is finished it reports the number of payload bytes it wrote.

The flash side is a byte-wide transaction port. `spi_cs_o` marks a frame. A byte moves when `spi_tx_valid_o` and `spi_tx_ready_i` are both high. The byte returned by the device during that same transfer appears on `spi_rx_i` in the cycle of the handshake. Serial clocking sits outside this block. The data stream is a valid/ready pair, and its ready output is high only while payload bytes are being sent. A request is accepted on `req_valid_i && req_ready_o`. Completion is a one-cycle `done_o` pulse, with `count_o` and `err_o` valid in the same cycle.

Top module: `flash_page_writer`

## Requirements
- R1: A program frame is byte 0x02, then the frame's address as three bytes with the high byte first, then the payload bytes in stream order. `spi_cs_o` stays high for the whole frame and goes low for at least one cycle between frames.
- R2: Each program frame is preceded by one or more status frames of two bytes, 0x05 then 0x00. The busy flag is bit 0 of the byte returned with the second byte. Status frames repeat while that bit is 1. After the first clear reading comes a write-enable frame of the single byte 0x06, and then the program frame.
- R3: No frame crosses a 256-byte page. The first frame carries the smaller of the request length and 256 minus (start address mod 256).
- R4: Each later frame carries the smaller of 256 and the bytes still left. Its address is the start address plus the bytes already sent.
- R5: `dat_ready_o` is low except during the payload phase of a program frame. Exactly as many stream bytes as the request length are consumed.
- R6: A request whose start plus length exceeds DEV_BYTES is rejected. `done_o` rises in the cycle after acceptance with `err_o`=1 and `count_o`=0, and no frame is sent.
- R7: After the last payload byte, `done_o` pulses for one cycle with `err_o`=0 and `count_o` equal to the payload bytes written. The 4 command bytes are not counted.
- R8: A zero-length request raises `done_o` in the cycle after acceptance with `count_o`=0 and `err_o`=0, and no frame is sent.
- R9: While `spi_tx_valid_o` is high and `spi_tx_ready_i` is low, outside the payload phase, the byte on `spi_tx_o` does not change and valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request offered |
| req_ready_o | output | 1 | Block idle, request accepted on valid |
| req_addr_i | input | 24 | Start byte address |
| req_len_i | input | LEN_W | Byte count |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected (valid with done_o) |
| count_o | output | LEN_W | Payload bytes written (valid with done_o) |
| dat_valid_i | input | 1 | Stream byte available |
| dat_ready_o | output | 1 | Stream byte taken this cycle |
| dat_i | input | 8 | Stream byte |
| spi_cs_o | output | 1 | Frame active |
| spi_tx_valid_o | output | 1 | Byte to send is valid |
| spi_tx_ready_i | input | 1 | Byte transfer completes this cycle |
| spi_tx_o | output | 8 | Byte to send |
| spi_rx_i | input | 8 | Byte received during the completing transfer |

## Verification
The assertions assume that `spi_rx_i` is meaningful only in cycles where a transfer completes. They also assume that the request fields are stable while `req_valid_i` is high and that no second request is offered before `done_o`. The bench device model drives the returned status only for the byte being transferred. It raises `req_valid_i` for exactly one idle cycle per request. It stalls both the flash port and the data stream with fixed patterns, so hold behaviour is covered without breaking either handshake.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_FILL = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT_CMD, S_STAT_RD, S_WREN, S_OP,
    S_A2, S_A1, S_A0, S_DATA, S_GAP, S_DONE
  } fpw_state_e;
endpackage

// File: rtl/fpw_range.sv
module fpw_range import fpw_pkg::*; #(
  parameter int LEN_W     = 25,
  parameter int DEV_BYTES = 1 << 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              zero_o,
  output logic              over_o
);
  localparam int SUM_W = ((LEN_W > ADDR_W) ? LEN_W : ADDR_W) + 1;

  logic [SUM_W-1:0] end_w;

  assign end_w  = SUM_W'(addr_i) + SUM_W'(len_i);
  assign zero_o = (len_i == '0);
  assign over_o = (end_w > SUM_W'(DEV_BYTES));
endmodule

// File: rtl/fpw_chunk.sv
module fpw_chunk #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 25
) (
  input  logic [PAGE_W-1:0] off_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [PAGE_W:0]   chunk_o
);
  localparam int PAGE = 1 << PAGE_W;

  logic [PAGE_W:0] room_w;

  // room to the next page boundary
  assign room_w  = (PAGE_W+1)'(PAGE) - {1'b0, off_i};
  assign chunk_o = (rem_i < LEN_W'(room_w)) ? rem_i[PAGE_W:0] : room_w;
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer import fpw_pkg::*; #(
  parameter int         PAGE_W    = 8,
  parameter int         LEN_W     = 25,
  parameter int         DEV_BYTES = 1 << 20,
  parameter logic [7:0] BUSY_MASK = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  count_o,
  input  logic              dat_valid_i,
  output logic              dat_ready_o,
  input  logic [7:0]        dat_i,
  output logic              spi_cs_o,
  output logic              spi_tx_valid_o,
  input  logic              spi_tx_ready_i,
  output logic [7:0]        spi_tx_o,
  input  logic [7:0]        spi_rx_i
);
  localparam int CHUNK_W = PAGE_W + 1;

  fpw_state_e          state_q, nxt_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LEN_W-1:0]    rem_q, count_q, len_q;
  logic [CHUNK_W-1:0]  chunk_q, chunk_w;
  logic                err_q;
  logic                zero_w, over_w, req_fire, fire, busy_w;

  fpw_range #(.LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)) u_range (
    .addr_i (req_addr_i),
    .len_i  (req_len_i),
    .zero_o (zero_w),
    .over_o (over_w)
  );

  fpw_chunk #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_chunk (
    .off_i   (addr_q[PAGE_W-1:0]),
    .rem_i   (rem_q),
    .chunk_o (chunk_w)
  );

  assign req_ready_o = (state_q == S_IDLE);
  assign req_fire    = req_valid_i & req_ready_o;
  assign done_o      = (state_q == S_DONE);
  assign err_o       = err_q;
  assign count_o     = count_q;
  assign busy_w      = |(spi_rx_i & BUSY_MASK);

  always_comb begin
    spi_tx_valid_o = 1'b1;
    spi_tx_o       = 8'h00;
    unique case (state_q)
      S_STAT_CMD: spi_tx_o = OP_STAT;
      S_STAT_RD:  spi_tx_o = OP_FILL;
      S_WREN:     spi_tx_o = OP_WREN;
      S_OP:       spi_tx_o = OP_PROG;
      S_A2:       spi_tx_o = addr_q[23:16];
      S_A1:       spi_tx_o = addr_q[15:8];
      S_A0:       spi_tx_o = addr_q[7:0];
      S_DATA: begin
        spi_tx_valid_o = dat_valid_i;
        spi_tx_o       = dat_i;
      end
      default:    spi_tx_valid_o = 1'b0;
    endcase
  end

  assign spi_cs_o    = !(state_q inside {S_IDLE, S_GAP, S_DONE});
  assign fire        = spi_tx_valid_o & spi_tx_ready_i;
  assign dat_ready_o = (state_q == S_DATA) & spi_tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      nxt_q   <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      len_q   <= '0;
      count_q <= '0;
      chunk_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_fire) begin
          addr_q  <= req_addr_i;
          rem_q   <= req_len_i;
          len_q   <= req_len_i;
          count_q <= '0;
          err_q   <= over_w;
          state_q <= (zero_w || over_w) ? S_DONE : S_STAT_CMD;
        end
        S_STAT_CMD: if (fire) state_q <= S_STAT_RD;
        S_STAT_RD: if (fire) begin
          nxt_q   <= busy_w ? S_STAT_CMD : S_WREN;
          state_q <= S_GAP;
        end
        S_WREN: if (fire) begin
          nxt_q   <= S_OP;
          state_q <= S_GAP;
        end
        S_OP: if (fire) begin
          chunk_q <= chunk_w;
          state_q <= S_A2;
        end
        S_A2: if (fire) state_q <= S_A1;
        S_A1: if (fire) state_q <= S_A0;
        S_A0: if (fire) state_q <= S_DATA;
        S_DATA: if (fire) begin
          addr_q  <= addr_q + 1'b1;
          rem_q   <= rem_q - 1'b1;
          count_q <= count_q + 1'b1;
          chunk_q <= chunk_q - 1'b1;
          if (chunk_q == CHUNK_W'(1)) begin
            nxt_q   <= (rem_q == LEN_W'(1)) ? S_DONE : S_STAT_CMD;
            state_q <= S_GAP;
          end
        end
        S_GAP:  state_q <= nxt_q;
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_NO_PAGE_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && fire && chunk_q != CHUNK_W'(1)) |->
      (&addr_q[PAGE_W-1:0]) == 1'b0); // R3

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_tx_valid_o && !spi_tx_ready_i && state_q != S_DATA) |=>
      (spi_tx_valid_o && $stable(spi_tx_o))); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |-> (count_q <= len_q)); // R7

  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && req_len_i == '0) |=>
      (done_o && count_o == '0 && !err_o && !spi_cs_o)); // R8

  AST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && over_w) |=> (done_o && err_o && !spi_cs_o)); // R6
endmodule

// File: tb/flash_page_writer_bench.sv
module flash_page_writer_bench;
  localparam int LEN_W = 25;
  localparam int DEV   = 1 << 20;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [23:0]       req_addr_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic              done_o, err_o;
  logic [LEN_W-1:0]  count_o;
  logic              dat_valid_i = 1'b0;
  logic              dat_ready_o;
  logic [7:0]        dat_i = '0;
  logic              spi_cs_o, spi_tx_valid_o;
  logic              spi_tx_ready_i = 1'b0;
  logic [7:0]        spi_tx_o;
  logic [7:0]        spi_rx_i = '0;

  flash_page_writer #(.LEN_W(LEN_W), .DEV_BYTES(DEV)) u_flash_page_writer (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i,
    .done_o, .err_o, .count_o, .dat_valid_i, .dat_ready_o, .dat_i,
    .spi_cs_o, .spi_tx_valid_o, .spi_tx_ready_i, .spi_tx_o, .spi_rx_i
  );

  always #4 clk_i = ~clk_i;

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] fbuf [0:2047];
  int fstart [0:63];
  int flen [0:63];
  int nfr = 0, wp = 0, cur_len = 0;
  int busy_cfg = 0, busy_left = 0, src_idx = 0;
  bit gap_en = 0;
  int gate_err = 0, hold_err = 0;
  bit prev_hold = 0;
  logic [7:0] prev_byte = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit in_payload();
    return (cur_len >= 4 && nfr < 64 && fbuf[fstart[nfr]] == 8'h02);
  endfunction

  // flash device model and stream source
  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    spi_tx_ready_i = (cyc % 3 != 1);
    dat_valid_i    = gap_en ? (cyc % 4 != 0) : 1'b1;
    dat_i          = 8'(src_idx * 13 + 5);
    spi_rx_i       = (busy_left > 0) ? 8'h03 : 8'h02;
    #1;
    if (!spi_cs_o && cur_len > 0) begin
      flen[nfr] = cur_len;
      if (nfr < 63) nfr++;
      cur_len = 0;
    end
    if (prev_hold && !(spi_tx_valid_o && spi_tx_o == prev_byte)) hold_err++;
    prev_hold = spi_tx_valid_o && !spi_tx_ready_i && !in_payload();
    prev_byte = spi_tx_o;
    if (dat_ready_o && !in_payload()) gate_err++;
    if (spi_tx_valid_o && spi_tx_ready_i) begin
      if (cur_len == 0) fstart[nfr] = wp;
      if (cur_len == 1 && fbuf[fstart[nfr]] == 8'h05 && busy_left > 0) busy_left--;
      if (cur_len == 0 && spi_tx_o == 8'h02) busy_left = busy_cfg;
      fbuf[wp] = spi_tx_o;
      if (wp < 2047) wp++;
      cur_len++;
    end
    if (dat_ready_o && dat_valid_i) src_idx++;
  end

  int lat, got_cnt;
  bit got_err;

  task automatic issue(input int addr, input int len, input int busy, input bit gaps);
    @(negedge clk_i);
    nfr = 0; wp = 0; cur_len = 0; src_idx = 0;
    busy_cfg = busy; busy_left = busy; gap_en = gaps;
    gate_err = 0; hold_err = 0;
    req_addr_i  = 24'(addr);
    req_len_i   = LEN_W'(len);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #2;
    lat = 0;
    while (!done_o && lat < 20000) begin
      @(negedge clk_i);
      #2;
      lat++;
    end
    got_cnt = int'(count_o);
    got_err = err_o;
    @(negedge clk_i);
  endtask

  task automatic check_frames(input int addr, input int len, input int busy);
    int f = 0, rem = len, a = addr, k = 0;
    while (rem > 0) begin
      int room = 256 - (a % 256);
      int chunk = (rem < room) ? rem : room;
      int bad = 0;
      for (int p = 0; p <= busy; p++) begin
        chk(flen[f] == 2 && fbuf[fstart[f]] == 8'h05 && fbuf[fstart[f]+1] == 8'h00,
            "R2 status frame", int'(fbuf[fstart[f]]), 5);
        f++;
      end
      chk(flen[f] == 1 && fbuf[fstart[f]] == 8'h06, "R2 write-enable frame",
          int'(fbuf[fstart[f]]), 6);
      f++;
      chk(fbuf[fstart[f]] == 8'h02, "R1 program opcode", int'(fbuf[fstart[f]]), 2);
      chk({fbuf[fstart[f]+1], fbuf[fstart[f]+2], fbuf[fstart[f]+3]} == 24'(a),
          (k == 0) ? "R1 frame address" : "R4 later frame address",
          int'({fbuf[fstart[f]+1], fbuf[fstart[f]+2], fbuf[fstart[f]+3]}), a);
      chk(flen[f] == chunk + 4, (k == 0) ? "R3 first frame length" : "R4 later frame length",
          flen[f] - 4, chunk);
      for (int j = 0; j < chunk; j++)
        if (fbuf[fstart[f]+4+j] != 8'((k + j) * 13 + 5)) bad++;
      chk(bad == 0, "R1 payload bytes", bad, 0);
      f++;
      a += chunk; rem -= chunk; k += chunk;
    end
    chk(nfr == f, "R1 frame total", nfr, f);
  endtask

  task automatic run_write(input int addr, input int len, input int busy, input bit gaps);
    issue(addr, len, busy, gaps);
    chk(lat < 20000 && !got_err, "R7 completion without error", int'(got_err), 0);
    chk(got_cnt == len, "R7 byte count", got_cnt, len);
    chk(src_idx == len, "R5 stream bytes consumed", src_idx, len);
    chk(gate_err == 0, "R5 stream held outside payload", gate_err, 0);
    chk(hold_err == 0, "R9 byte held while stalled", hold_err, 0);
    check_frames(addr, len, busy);
  endtask

  task automatic t_reset();
    chk(req_ready_o && !spi_cs_o && !dat_ready_o && !done_o && !spi_tx_valid_o,
        "R7 reset state idle", int'(spi_cs_o), 0);
  endtask

  task automatic t_zero();
    issue(32'h123, 0, 0, 0);
    chk(lat == 0, "R8 zero-length done next cycle", lat, 0);
    chk(got_cnt == 0 && !got_err, "R8 zero-length count", got_cnt, 0);
    chk(nfr == 0 && cur_len == 0, "R8 zero-length no traffic", nfr, 0);
  endtask

  task automatic t_reject();
    issue(DEV - 16, 17, 0, 0);
    chk(lat == 0 && got_err, "R6 overflow rejected", int'(got_err), 1);
    chk(got_cnt == 0, "R6 rejected count", got_cnt, 0);
    chk(nfr == 0 && cur_len == 0 && src_idx == 0, "R6 rejected no traffic", nfr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    t_reset();
    run_write(24'h000010, 5, 0, 0);     // single frame inside a page
    run_write(24'h0001F0, 40, 2, 0);    // crosses one boundary, busy polls
    run_write(24'h000380, 600, 1, 1);   // three frames, stream gaps
    run_write(24'h000400, 256, 0, 0);   // exactly one aligned page
    t_zero();
    t_reject();
    run_write(DEV - 16, 16, 0, 1);      // ends exactly at device size
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule